// File: doc/BRIEF.md
# Carry-Free Quaternary Signed-Digit Adder

This block adds two N-digit radix-4 signed-digit numbers in constant depth. Each digit holds a value from -3 to +3 in a 3-bit two's complement field, so one number has several possible digit strings. The adder uses that redundancy to stop carries from travelling more than one position. In the first stage, every digit position turns the sum of its two operand digits into a small transfer digit and a small residual digit. In the second stage, each position adds its residual to the transfer from the position just below it.

The block is purely combinational and has no clock. Its delay is the same for any digit count. The transfer that leaves the top position is brought out as one more digit of weight 4^N. Feeding the code 100 (-4) into an operand digit is outside the contract. The intended use is as the adder core of a wider redundant-arithmetic datapath, where operands and results stay in signed-digit form.

Top module: `qsd_carry_free_adder`

## Requirements
- R1: Digit i of every operand and result vector sits at bits [3i+2:3i] as 3-bit two's complement, with weight 4^i. The digit count N is a parameter with a default of 16.
- R2: For all legal operands, value(sum_o) + 4^N·value(carry_o) equals value(augend_i) + value(addend_i).
- R3: Every result digit and the carry-out digit lie in -3..+3. The carry-out digit lies in -1..+1, so the code 100 never appears.
- R4: The raw digit sum r = a+b is split as r = 4c + s as follows. If r ≥ 3, then c = +1. If r ≤ -3, then c = -1. Otherwise c = 0. In every case s = r - 4c.
- R5: Nothing enters below digit 0, so result digit 0 equals the residual s of position 0 alone.
- R6: The carry-out digit equals the transfer c of position N-1, sign-extended to 3 bits.
- R7: Result digit i depends only on the operand digits at positions i and i-1. Changing operand digits at positions j and above leaves result digits 0..j-1 unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| augend_i | input | 3*N | First operand, N signed digits |
| addend_i | input | 3*N | Second operand, N signed digits |
| sum_o | output | 3*N | Result digits 0..N-1 |
| carry_o | output | 3 | Result digit N (transfer out of the top position) |

## Verification
The hardest condition to reach is a transfer produced in one position meeting a residual of the same sign in the next position. For example, +3+3 below +1+1 gives a residual of +2 and an incoming +1, which pushes the output digit to the ±3 edge of its range. Random digits seldom line up this way, so directed patterns fill every position with the same extreme pair, or alternate extreme pairs. A separate sweep runs all 49 digit pairs through position 0 and through the top position, so the transfer split and the carry-out digit are checked for every raw sum. A locality scenario then keeps the low digits fixed and changes the high digits, to show that no carry crosses more than one position.

// File: rtl/qsd_pkg.sv
package qsd_pkg;
  localparam int unsigned DIGIT_W = 3;
  typedef logic signed [DIGIT_W-1:0] qdigit_t;
  localparam qdigit_t QD_ZERO = 3'sd0;
endpackage

// File: rtl/qsd_recode.sv
module qsd_recode
  import qsd_pkg::*;
(
  input  logic [DIGIT_W-1:0] a_i,
  input  logic [DIGIT_W-1:0] b_i,
  output logic [DIGIT_W-1:0] xfer_o,
  output logic [DIGIT_W-1:0] resid_o
);
  logic signed [DIGIT_W:0] raw;
  logic signed [DIGIT_W:0] resid_w;
  logic        [1:0]       xfer2;

  always_comb begin
    raw = {a_i[DIGIT_W-1], a_i} + {b_i[DIGIT_W-1], b_i};
    if (raw >= 4'sd3) begin
      xfer2   = 2'b01;
      resid_w = raw - 4'sd4;
    end else if (raw <= -4'sd3) begin
      xfer2   = 2'b11;
      resid_w = raw + 4'sd4;
    end else begin
      xfer2   = 2'b00;
      resid_w = raw;
    end
  end

  assign xfer_o  = {xfer2[1], xfer2};
  assign resid_o = resid_w[DIGIT_W-1:0];
endmodule

// File: rtl/qsd_merge.sv
module qsd_merge
  import qsd_pkg::*;
(
  input  logic [DIGIT_W-1:0] resid_i,
  input  logic [DIGIT_W-1:0] xfer_lo_i,
  output logic [DIGIT_W-1:0] digit_o
);
  assign digit_o = resid_i + xfer_lo_i;
endmodule

// File: rtl/qsd_carry_free_adder.sv
module qsd_carry_free_adder
  import qsd_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input  logic [DIGIT_W*N-1:0] augend_i,
  input  logic [DIGIT_W*N-1:0] addend_i,
  output logic [DIGIT_W*N-1:0] sum_o,
  output logic [DIGIT_W-1:0]   carry_o
);
  localparam int unsigned CHAIN_W = DIGIT_W * (N + 1);

  logic [CHAIN_W-1:0]   xfer_chain;
  logic [DIGIT_W*N-1:0] resid_vec;

  assign xfer_chain[DIGIT_W-1:0] = QD_ZERO;

  for (genvar i = 0; i < N; i++) begin : g_pos
    qsd_recode u_recode (
      .a_i    (augend_i[DIGIT_W*i +: DIGIT_W]),
      .b_i    (addend_i[DIGIT_W*i +: DIGIT_W]),
      .xfer_o (xfer_chain[DIGIT_W*(i+1) +: DIGIT_W]),
      .resid_o(resid_vec[DIGIT_W*i +: DIGIT_W])
    );
    qsd_merge u_merge (
      .resid_i  (resid_vec[DIGIT_W*i +: DIGIT_W]),
      .xfer_lo_i(xfer_chain[DIGIT_W*i +: DIGIT_W]),
      .digit_o  (sum_o[DIGIT_W*i +: DIGIT_W])
    );
  end

  assign carry_o = xfer_chain[DIGIT_W*N +: DIGIT_W];
endmodule

// File: rtl/qsd_adder_chk.sv
module qsd_adder_chk
  import qsd_pkg::*;
#(
  parameter int unsigned N = 16
) (
  input logic [DIGIT_W*N-1:0] augend_i,
  input logic [DIGIT_W*N-1:0] addend_i,
  input logic [DIGIT_W*N-1:0] sum_o,
  input logic [DIGIT_W-1:0]   carry_o
);
  function automatic longint unsigned vec_val(input logic [DIGIT_W*N-1:0] v);
    longint unsigned acc;
    acc = 0;
    for (int k = N - 1; k >= 0; k--) begin
      acc = (acc << 2) + longint'(signed'(v[DIGIT_W*k +: DIGIT_W]));
    end
    return acc;
  endfunction

  logic legal_in;
  logic signed [DIGIT_W:0] raw0, rawt;
  logic signed [DIGIT_W-1:0] d0;
  longint unsigned lhs, rhs;

  always_comb begin
    legal_in = !$isunknown({augend_i, addend_i, sum_o, carry_o});
    for (int k = 0; k < N; k++) begin
      if (augend_i[DIGIT_W*k +: DIGIT_W] == 3'b100 || addend_i[DIGIT_W*k +: DIGIT_W] == 3'b100)
        legal_in = 1'b0;
    end
    raw0 = {augend_i[2], augend_i[2:0]} + {addend_i[2], addend_i[2:0]};
    rawt = {augend_i[DIGIT_W*N-1], augend_i[DIGIT_W*N-1 -: DIGIT_W]}
         + {addend_i[DIGIT_W*N-1], addend_i[DIGIT_W*N-1 -: DIGIT_W]};
    d0  = signed'(sum_o[2:0]);
    lhs = vec_val(sum_o) + (longint'(signed'(carry_o)) << (2 * N));
    rhs = vec_val(augend_i) + vec_val(addend_i);
    if (legal_in) begin
      for (int k = 0; k < N; k++) begin
        assert_digit_range_R3: assert (sum_o[DIGIT_W*k +: DIGIT_W] != 3'b100)
          else $error("result digit %0d holds code 100", k);
      end
      assert_carry_range_R3: assert (carry_o == 3'b000 || carry_o == 3'b001 || carry_o == 3'b111)
        else $error("carry-out digit out of range");
      assert_value_R2: assert (lhs == rhs)
        else $error("numeric value mismatch");
      assert_low_digit_R5: assert (d0 >= -3'sd2 && d0 <= 3'sd2
                                   && ((raw0 - {d0[2], d0}) & 4'sd3) == 4'sd0)
        else $error("digit 0 not the bare residual");
      assert_top_carry_R6: assert ((rawt >= 4'sd3) == (carry_o == 3'b001)
                                   && (rawt <= -4'sd3) == (carry_o == 3'b111))
        else $error("carry-out digit disagrees with top raw sum");
    end
  end
endmodule

bind qsd_carry_free_adder qsd_adder_chk #(.N(N)) u_chk (
  .augend_i(augend_i),
  .addend_i(addend_i),
  .sum_o   (sum_o),
  .carry_o (carry_o)
);

// File: tb/qsd_carry_free_adder_tb.sv
module qsd_carry_free_adder_tb;
  localparam int N  = 16;
  localparam int VW = 3 * N;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic [VW-1:0] a, b, s;
  logic [2:0]    co;
  int n_chk = 0;
  int n_bad = 0;

  qsd_carry_free_adder #(.N(N)) u_dut (
    .augend_i(a), .addend_i(b), .sum_o(s), .carry_o(co)
  );

  function automatic longint vval(input logic [VW-1:0] v);
    longint acc = 0;
    for (int k = N - 1; k >= 0; k--) acc = acc * 4 + longint'(signed'(v[3*k +: 3]));
    return acc;
  endfunction

  function automatic int dg(input logic [VW-1:0] v, input int k);
    return int'(signed'(v[3*k +: 3]));
  endfunction

  function automatic logic [2:0] enc(input int d);
    logic [2:0] r;
    r = d[2:0];
    return r;
  endfunction

  function automatic int xfer_of(input int r);
    return (r >= 3) ? 1 : ((r <= -3) ? -1 : 0);
  endfunction

  function automatic logic [2:0] rnd_digit();
    return enc(int'($urandom % 7) - 3);
  endfunction

  task automatic check(input string req, input longint act, input longint exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic apply(input logic [VW-1:0] x, input logic [VW-1:0] y);
    @(negedge clk);
    a = x; b = y;
    #1;
  endtask

  task automatic check_value_range(input string tag);
    check({tag, " R2 value"}, vval(s) + longint'(dg({{(VW-3){1'b0}}, co}, 0)) * (longint'(1) << (2 * N)),
          vval(a) + vval(b));
    for (int k = 0; k < N; k++) begin
      check({tag, " R3 digit range"}, longint'(dg(s, k) >= -3 && dg(s, k) <= 3), 1);
    end
    check({tag, " R3 carry range"}, longint'(dg({{(VW-3){1'b0}}, co}, 0) >= -1
                                  && dg({{(VW-3){1'b0}}, co}, 0) <= 1), 1);
  endtask

  task automatic t_zero();
    apply('0, '0);
    check("R1 zero sum", vval(s), 0);
    check("R6 zero carry", longint'(co), 0);
  endtask

  task automatic t_digit_pairs();
    for (int x = -3; x <= 3; x++) begin
      for (int y = -3; y <= 3; y++) begin
        logic [VW-1:0] xa, ya;
        int r, c;
        r = x + y; c = xfer_of(r);
        xa = '0; ya = '0;
        xa[2:0] = enc(x); ya[2:0] = enc(y);
        xa[VW-1 -: 3] = enc(x); ya[VW-1 -: 3] = enc(y);
        apply(xa, ya);
        check("R4 R5 digit0 residual", dg(s, 0), r - 4 * c);
        check("R4 digit1 transfer", dg(s, 1), c);
        check("R6 carry-out", dg({{(VW-3){1'b0}}, co}, 0), c);
        check_value_range("pairs");
      end
    end
  endtask

  task automatic t_extremes();
    logic [VW-1:0] p, m, alt;
    for (int k = 0; k < N; k++) begin
      p[3*k +: 3] = enc(3);
      m[3*k +: 3] = enc(-3);
      alt[3*k +: 3] = (k % 2 == 0) ? enc(3) : enc(-3);
    end
    apply(p, p);
    check("R4 all +3 digit1", dg(s, 1), 3);
    check_value_range("all+3");
    apply(m, m);
    check("R4 all -3 digit1", dg(s, 1), -3);
    check_value_range("all-3");
    apply(alt, alt);
    check_value_range("alternating");
    apply(p, m);
    check("R2 cancel", vval(s), 0);
  endtask

  task automatic t_locality();
    for (int t = 0; t < 40; t++) begin
      logic [VW-1:0] xa, ya, first;
      int j;
      for (int k = 0; k < N; k++) begin xa[3*k +: 3] = rnd_digit(); ya[3*k +: 3] = rnd_digit(); end
      j = 1 + int'($urandom % (N - 1));
      apply(xa, ya);
      first = s;
      for (int k = j; k < N; k++) begin xa[3*k +: 3] = rnd_digit(); ya[3*k +: 3] = rnd_digit(); end
      apply(xa, ya);
      for (int k = 0; k < j; k++) check("R7 low digits unchanged", dg(s, k), dg(first, k));
      check_value_range("locality");
    end
  endtask

  task automatic t_random();
    for (int t = 0; t < 2000; t++) begin
      logic [VW-1:0] xa, ya;
      for (int k = 0; k < N; k++) begin xa[3*k +: 3] = rnd_digit(); ya[3*k +: 3] = rnd_digit(); end
      apply(xa, ya);
      check_value_range("random");
      check("R5 digit0", dg(s, 0), dg(xa, 0) + dg(ya, 0) - 4 * xfer_of(dg(xa, 0) + dg(ya, 0)));
    end
  endtask

  initial begin
    a = '0; b = '0;
    t_zero();
    t_digit_pairs();
    t_extremes();
    t_locality();
    t_random();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    #(5.0 * 200000);
    n_chk++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule